// File: doc/BRIEF.md
# Transmit Source Priority Arbiter

This block decides which of four word sources is handed to a serial avionics transmit controller next. The sources are an urgent single-word holding register, the output of a transmit scheduler, a background single-word holding register, and a deep transmit queue. The two holding registers are loaded by host writes. The scheduler and the queue each present a word together with a valid flag, and each expects a one-cycle acknowledge when that word has been taken.

The controller raises a ready input when it can take a word. In that cycle the block picks one pending source by a fixed ranking and loads the word toward the controller. It never interrupts a word that is already in flight. A control bit swaps between two rankings. A second control bit makes the queue send at most one word per tick of a programmable timebase instead of sending freely. On its way out, the most significant bit of the word (bit index 31, the 32nd bit on the wire) is replaced by odd or even parity, or it is left exactly as the source supplied it.

Top module: `txarb_top`

## Requirements
- R1: With `cfg_fifo_first` = 0, a grant goes to the first pending source in the ranking urgent register, scheduler, background register, queue.
- R2: With `cfg_fifo_first` = 1, a grant goes to the first pending source in the ranking queue, scheduler, background register, urgent register.
- R3: A grant happens at a clock edge where `ctl_ready` is 1, `ctl_load` is 0 and at least one source is pending. `ctl_load` is 1 for exactly the following cycle. When `ctl_ready` is 0, no word is loaded.
- R4: `ctl_load` comes with exactly one acknowledge (`hi_ack`, `sched_ack`, `lo_ack`, `fifo_ack`) in the same cycle, naming the granted source. With no load, every acknowledge is 0.
- R5: `cfg_parity` = 2'b01 or 2'b11 selects odd parity and 2'b10 selects even parity. In either case `ctl_word[31]` is set so that the 32-bit word has the selected parity, whatever bit 31 the source supplied, and bits 30..0 pass unchanged.
- R6: `cfg_parity` = 2'b00 passes all 32 bits of the granted word unchanged, including the source's bit 31.
- R7: A holding register becomes pending on a host write and stops pending when it is granted. A write in the same cycle as that register's grant sends the old word and leaves the new word pending.
- R8: With `cfg_paced` = 0, a queue word that is continuously valid is granted on every cycle the controller allows, which is every second cycle when `ctl_ready` stays at 1.
- R9: With `cfg_paced` = 1, a timebase that ticks every `cfg_pace_div` cycles (or every cycle when the value is 0) grants at most one queue word per tick. Ticks that go unused do not accumulate beyond one word.
- R10: While `rst` is high and in the first cycle after it, `ctl_load` and all acknowledges are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_wr | input | 1 | Host write strobe for the urgent register |
| hi_wdata | input | WORD_W | Word written to the urgent register |
| lo_wr | input | 1 | Host write strobe for the background register |
| lo_wdata | input | WORD_W | Word written to the background register |
| sched_valid | input | 1 | Scheduler word is available |
| sched_word | input | WORD_W | Scheduler word |
| fifo_valid | input | 1 | Queue is not empty |
| fifo_word | input | WORD_W | Word at the head of the queue |
| cfg_fifo_first | input | 1 | Selects the ranking that puts the queue first |
| cfg_parity | input | 2 | Parity mode: 00 none, 01/11 odd, 10 even |
| cfg_paced | input | 1 | Queue sends only on timebase ticks |
| cfg_pace_div | input | PACE_W | Timebase period in cycles |
| ctl_ready | input | 1 | Controller can accept a word |
| ctl_load | output | 1 | Word on ctl_word is handed to the controller |
| ctl_word | output | WORD_W | Granted word with parity applied |
| hi_ack | output | 1 | Urgent register word taken |
| sched_ack | output | 1 | Scheduler word taken |
| lo_ack | output | 1 | Background register word taken |
| fifo_ack | output | 1 | Queue word taken (pop) |

## Verification
The case that matters most is a host write to a holding register landing in the same cycle that register wins a grant. The write strobe is driven in the grant cycle with a different word. The bench then expects the old word on `ctl_word`, no second load in the blocked cycle that follows, and the new word at the next opportunity. The other collision is a pacing tick arriving in the same cycle the queue is granted. The bench provokes it by holding the queue valid and the controller ready for many tick periods, and it judges the count of queue grants against the number of ticks in the window. Ranking, parity and the handling of the source's bit 31 are swept over every set of pending sources, under both rankings and all parity modes.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

    localparam int NSRC = 4;

    typedef enum logic [1:0] {
        SRC_HI    = 2'd0,
        SRC_SCHED = 2'd1,
        SRC_LO    = 2'd2,
        SRC_FIFO  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_ODD_B = 2'b11
    } par_e;

    // Source that occupies a given rank (0 = most urgent) for the selected order.
    function automatic src_e rank_src(input logic fifo_first, input int unsigned pos);
        src_e s;
        case (pos)
            0:       s = fifo_first ? SRC_FIFO : SRC_HI;
            1:       s = SRC_SCHED;
            2:       s = SRC_LO;
            default: s = fifo_first ? SRC_HI : SRC_FIFO;
        endcase
        return s;
    endfunction

    function automatic logic [NSRC-1:0] src_onehot(input src_e s);
        logic [NSRC-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/txarb_hold_reg.sv
module txarb_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic         valid,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
        end else begin
            if (wr) begin
                valid <= 1'b1;
                word  <= wdata;
            end else if (take) begin
                valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/txarb_pacer.sv
module txarb_pacer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] div,
    input  logic             consume,
    output logic             credit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             tick;

    assign last = (div == '0) ? '0 : div - 1'b1;
    assign tick = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            credit <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)
                credit <= 1'b1;
            else if (consume)
                credit <= 1'b0;
        end
    end
endmodule

// File: rtl/txarb_pick.sv
module txarb_pick
    import txarb_pkg::*;
(
    input  logic            fifo_first,
    input  logic [NSRC-1:0] req,
    output logic            any,
    output src_e            win
);
    logic [NSRC-1:0] req_ranked;

    for (genvar r = 0; r < NSRC; r++) begin : g_rank
        assign req_ranked[r] = req[rank_src(fifo_first, r)];
    end

    always_comb begin
        any = 1'b0;
        win = SRC_HI;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (req_ranked[r]) begin
                any = 1'b1;
                win = rank_src(fifo_first, r);
            end
        end
    end
endmodule

// File: rtl/txarb_parity.sv
module txarb_parity
    import txarb_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic body_odd;
    assign body_odd = ^din[W-2:0];

    always_comb begin
        case (par_e'(mode))
            PAR_NONE: dout = din;
            PAR_EVEN: dout = {body_odd, din[W-2:0]};
            default:  dout = {~body_odd, din[W-2:0]};
        endcase
    end
endmodule

// File: rtl/txarb_top.sv
module txarb_top
    import txarb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PACE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hi_wr,
    input  logic [WORD_W-1:0] hi_wdata,
    input  logic              lo_wr,
    input  logic [WORD_W-1:0] lo_wdata,
    input  logic              sched_valid,
    input  logic [WORD_W-1:0] sched_word,
    input  logic              fifo_valid,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              cfg_fifo_first,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_paced,
    input  logic [PACE_W-1:0] cfg_pace_div,
    input  logic              ctl_ready,
    output logic              ctl_load,
    output logic [WORD_W-1:0] ctl_word,
    output logic              hi_ack,
    output logic              sched_ack,
    output logic              lo_ack,
    output logic              fifo_ack
);
    logic              hi_valid, lo_valid;
    logic [WORD_W-1:0] hi_word, lo_word;
    logic              pace_credit;
    logic              fifo_req;
    logic [NSRC-1:0]   req;
    logic              win_any;
    src_e              win;
    logic              grant_ok;
    logic [NSRC-1:0]   grant_vec;
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] out_word;

    txarb_hold_reg #(.W(WORD_W)) u_hi (
        .clk(clk), .rst(rst), .wr(hi_wr), .wdata(hi_wdata),
        .take(grant_vec[SRC_HI]), .valid(hi_valid), .word(hi_word)
    );

    txarb_hold_reg #(.W(WORD_W)) u_lo (
        .clk(clk), .rst(rst), .wr(lo_wr), .wdata(lo_wdata),
        .take(grant_vec[SRC_LO]), .valid(lo_valid), .word(lo_word)
    );

    txarb_pacer #(.CNT_W(PACE_W)) u_pace (
        .clk(clk), .rst(rst), .div(cfg_pace_div),
        .consume(grant_vec[SRC_FIFO]), .credit(pace_credit)
    );

    assign fifo_req = fifo_valid && (!cfg_paced || pace_credit);

    always_comb begin
        req = '0;
        req[SRC_HI]    = hi_valid;
        req[SRC_SCHED] = sched_valid;
        req[SRC_LO]    = lo_valid;
        req[SRC_FIFO]  = fifo_req;
    end

    txarb_pick u_pick (
        .fifo_first(cfg_fifo_first), .req(req), .any(win_any), .win(win)
    );

    // The controller is busy for the cycle in which a word is being loaded.
    assign grant_ok  = ctl_ready && !ctl_load;
    assign grant_vec = (grant_ok && win_any) ? src_onehot(win) : '0;

    always_comb begin
        case (win)
            SRC_HI:    sel_word = hi_word;
            SRC_SCHED: sel_word = sched_word;
            SRC_LO:    sel_word = lo_word;
            default:   sel_word = fifo_word;
        endcase
    end

    txarb_parity #(.W(WORD_W)) u_par (
        .mode(cfg_parity), .din(sel_word), .dout(out_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_load  <= 1'b0;
            ctl_word  <= '0;
            hi_ack    <= 1'b0;
            sched_ack <= 1'b0;
            lo_ack    <= 1'b0;
            fifo_ack  <= 1'b0;
        end else begin
            ctl_load  <= |grant_vec;
            hi_ack    <= grant_vec[SRC_HI];
            sched_ack <= grant_vec[SRC_SCHED];
            lo_ack    <= grant_vec[SRC_LO];
            fifo_ack  <= grant_vec[SRC_FIFO];
            if (|grant_vec)
                ctl_word <= out_word;
        end
    end
endmodule

// File: rtl/txarb_chk.sv
module txarb_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_ready,
    input logic              ctl_load,
    input logic [WORD_W-1:0] ctl_word,
    input logic              hi_ack,
    input logic              sched_ack,
    input logic              lo_ack,
    input logic              fifo_ack,
    input logic [1:0]        cfg_parity,
    input logic              cfg_fifo_first,
    input logic              hi_pend,
    input logic              fifo_pend
);
    logic [3:0] acks;
    assign acks = {fifo_ack, lo_ack, sched_ack, hi_ack};

    assert_one_ack_R4: assert property (@(posedge clk) disable iff (rst)
        ctl_load |-> $countones(acks) == 1);

    assert_no_stray_ack_R4: assert property (@(posedge clk) disable iff (rst)
        !ctl_load |-> acks == 4'b0000);

    assert_ready_gate_R3: assert property (@(posedge clk) disable iff (rst)
        ctl_load |-> ($past(ctl_ready) && !$past(ctl_load)));

    assert_odd_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_load && $past(cfg_parity[0])) |-> (^ctl_word) == 1'b1);

    assert_even_parity_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_load && $past(cfg_parity) == 2'b10) |-> (^ctl_word) == 1'b0);

    assert_hi_first_R1: assert property (@(posedge clk) disable iff (rst)
        (ctl_load && $past(!cfg_fifo_first && hi_pend)) |-> hi_ack);

    assert_fifo_first_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_load && $past(cfg_fifo_first && fifo_pend)) |-> fifo_ack);
endmodule

bind txarb_top txarb_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_ready(ctl_ready), .ctl_load(ctl_load),
    .ctl_word(ctl_word), .hi_ack(hi_ack), .sched_ack(sched_ack),
    .lo_ack(lo_ack), .fifo_ack(fifo_ack), .cfg_parity(cfg_parity),
    .cfg_fifo_first(cfg_fifo_first), .hi_pend(hi_valid), .fifo_pend(fifo_req)
);

// File: tb/txarb_top_tb.sv
module txarb_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        hi_wr, lo_wr, sched_valid, fifo_valid;
    logic [31:0] hi_wdata, lo_wdata, sched_word, fifo_word;
    logic        cfg_fifo_first, cfg_paced;
    logic [1:0]  cfg_parity;
    logic [15:0] cfg_pace_div;
    logic        ctl_ready;
    logic        ctl_load;
    logic [31:0] ctl_word;
    logic        hi_ack, sched_ack, lo_ack, fifo_ack;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txarb_top u_dut (
        .clk(clk), .rst(rst),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .sched_valid(sched_valid), .sched_word(sched_word),
        .fifo_valid(fifo_valid), .fifo_word(fifo_word),
        .cfg_fifo_first(cfg_fifo_first), .cfg_parity(cfg_parity),
        .cfg_paced(cfg_paced), .cfg_pace_div(cfg_pace_div),
        .ctl_ready(ctl_ready), .ctl_load(ctl_load), .ctl_word(ctl_word),
        .hi_ack(hi_ack), .sched_ack(sched_ack), .lo_ack(lo_ack), .fifo_ack(fifo_ack)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] w, input logic [1:0] mode);
        int ones;
        logic [31:0] r;
        ones = $countones(w[30:0]);
        r = w;
        if (mode == 2'b10)      r[31] = (ones % 2 == 1);
        else if (mode != 2'b00) r[31] = (ones % 2 == 0);
        return r;
    endfunction

    function automatic logic [3:0] onehot4(input int i);
        logic [3:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    task automatic drain();
        sched_valid = 0; fifo_valid = 0; ctl_ready = 1;
        repeat (4) step();
        ctl_ready = 0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; hi_wr = 0; lo_wr = 0; sched_valid = 0; fifo_valid = 0;
        hi_wdata = 0; lo_wdata = 0; sched_word = 0; fifo_word = 0;
        cfg_fifo_first = 0; cfg_paced = 0; cfg_parity = 0; cfg_pace_div = 0;
        ctl_ready = 1;
        @(negedge clk);
        step(); step();
        check("R10 load in reset", ctl_load, 0);
        check("R10 acks in reset", {fifo_ack, lo_ack, sched_ack, hi_ack}, 0);
        rst = 0;
        step();
        check("R10 load after reset", ctl_load, 0);
        ctl_ready = 0;
        step();

        // Sweep: every pending-source mask, both rankings, all parity modes (R1 R2 R5 R6 R4 R3)
        for (int ord = 0; ord < 2; ord++) begin
            for (int par = 0; par < 4; par++) begin
                for (int mask = 0; mask < 16; mask++) begin
                    logic [31:0] w [4];
                    int win;
                    int id;
                    id = ord * 64 + par * 16 + mask;
                    for (int s = 0; s < 4; s++)
                        w[s] = (32'h9E37_79B9 * (id * 4 + s + 1)) ^ {s[0], 31'h0};
                    cfg_fifo_first = ord[0];
                    cfg_parity = par[1:0];
                    ctl_ready = 0;
                    hi_wr = mask[0]; hi_wdata = w[0];
                    lo_wr = mask[2]; lo_wdata = w[2];
                    step();
                    hi_wr = 0; lo_wr = 0;
                    sched_valid = mask[1]; sched_word = w[1];
                    fifo_valid = mask[3]; fifo_word = w[3];
                    ctl_ready = 1;
                    step();
                    win = -1;
                    if (ord == 0) begin
                        for (int r = 3; r >= 0; r--) if (mask[r]) win = r;
                    end else begin
                        if (mask[0]) win = 0;
                        if (mask[2]) win = 2;
                        if (mask[1]) win = 1;
                        if (mask[3]) win = 3;
                    end
                    if (win < 0) begin
                        check("R3 no load when idle", ctl_load, 0);
                    end else begin
                        check(ord == 0 ? "R1 ack choice" : "R2 ack choice",
                              {fifo_ack, lo_ack, sched_ack, hi_ack}, onehot4(win));
                        check(par == 0 ? "R6 word passthrough" : "R5 parity word",
                              ctl_word, exp_word(w[win], par[1:0]));
                        check("R3 load pulse", ctl_load, 1);
                    end
                    drain();
                end
            end
        end

        // R3: no load while controller busy, then single load, then blocked cycle
        cfg_fifo_first = 0; cfg_parity = 0;
        ctl_ready = 0; hi_wr = 1; hi_wdata = 32'h8000_1234;
        step();
        hi_wr = 0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R3 no load while busy", ctl_load, 0);
        end
        ctl_ready = 1;
        step();
        check("R3 load when ready", ctl_load, 1);
        check("R3 urgent word", ctl_word, 32'h8000_1234);
        step();
        check("R3 blocked after load", ctl_load, 0);
        ctl_ready = 0;
        step();

        // R7: write colliding with grant of the same register
        hi_wr = 1; hi_wdata = 32'h0000_00AA;
        step();
        ctl_ready = 1; hi_wdata = 32'h0000_00BB;
        step();
        hi_wr = 0;
        check("R7 old word sent on collision", ctl_word, 32'h0000_00AA);
        check("R7 ack on collision", hi_ack, 1);
        step();
        check("R7 blocked cycle", ctl_load, 0);
        step();
        check("R7 new word still pending", ctl_word, 32'h0000_00BB);
        check("R7 new word ack", hi_ack, 1);
        step();
        step();
        check("R7 cleared after grant", ctl_load, 0);
        ctl_ready = 0;
        step();

        // R8: free-running queue, ready held high
        begin
            int loads;
            loads = 0;
            fifo_valid = 1; fifo_word = 32'h1357_2468; ctl_ready = 1;
            for (int i = 0; i < 20; i++) begin
                step();
                if (fifo_ack) loads++;
            end
            check("R8 free queue grant count", loads, 10);
            fifo_valid = 0; ctl_ready = 0;
            step(); step();
        end

        // R9: paced queue, period 5
        begin
            int loads;
            cfg_paced = 1; cfg_pace_div = 5;
            step();
            loads = 0;
            fifo_valid = 1; ctl_ready = 1;
            for (int i = 0; i < 50; i++) begin
                step();
                if (fifo_ack) loads++;
            end
            checks++;
            if (loads < 9 || loads > 11) begin
                errors++;
                $display("FAIL R9 paced grant count actual=%0d expected=9..11", loads);
            end
            // Idle through several ticks: only one banked word
            fifo_valid = 0;
            repeat (20) step();
            cfg_pace_div = 200;
            fifo_valid = 1;
            loads = 0;
            for (int i = 0; i < 20; i++) begin
                step();
                if (fifo_ack) loads++;
            end
            check("R9 unused ticks do not accumulate", loads, 1);
            fifo_valid = 0; ctl_ready = 0; cfg_paced = 0;
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule